// File: doc/BRIEF.md
# JTAG Bus Monitor and Scan Decoder

This block watches a four-wire JTAG link without driving it. It oversamples the test clock, mode select, data-in and data-out lines with a faster system clock. It keeps its own copy of the 16-state test access port controller in lockstep with the target. Each rising test clock edge produces a one-cycle event that carries the state just left and the state just entered. The present state is always visible on an output.

During every instruction-register or data-register scan the block gathers the bits on the data-in and data-out lines side by side. The first bit shifted becomes the least significant bit. When the scan enters its Update state, the block publishes one record. The record carries an instruction/data tag, both bit vectors, the number of bits and an overflow flag. It stays on the record outputs until the next record replaces it. A debug trace unit or an on-chip logic analyser would typically consume these records.

Top module: `jtmon_top`

## Requirements
- R1: States are encoded on 4 bits as: 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR. After reset the tracked state is Run-Test/Idle (1), and no event or record strobe is active.
- R2: On each rising test clock edge the state moves by the standard controller rule, using the mode select value at that edge (select 1 / 0). Test-Logic-Reset goes to itself / Run-Test/Idle. Run-Test/Idle goes to Select-DR / itself. Select-DR goes to Select-IR / Capture-DR. Select-IR goes to Test-Logic-Reset / Capture-IR. Capture goes to Exit1 / Shift. Shift goes to Exit1 / Shift. Exit1 goes to Update / Pause. Pause goes to Exit2 / Pause. Exit2 goes to Update / Shift. Update goes to Select-DR / Run-Test/Idle.
- R3: A falling test clock edge, or no edge at all, changes neither the state nor the event outputs.
- R4: Every rising test clock edge raises the change strobe for exactly one system clock. The strobe carries the state before the edge and the state after it.
- R5: On each rising edge whose previous state is Shift-DR or Shift-IR, the data-in and data-out values are both stored. The first stored bit is bit 0 of each vector.
- R6: The value present on an edge that leaves Exit1, toward Update or toward Pause, is not stored and is not counted.
- R7: Entering Update-DR or Update-IR raises the record strobe for one system clock. The tag is 1 for Update-IR and 0 for Update-DR. The record outputs hold until the next record.
- R8: The record count equals the number of stored bits, and a scan with no Shift edge reports a count of 0. Vector bits at or above the count are 0.
- R9: Bits beyond the vector width W are dropped, the count stops at W, and the record overflow flag is 1. Otherwise the flag is 0.
- R10: Collection restarts empty on entry to either Capture state and after each record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the test clock rate |
| rst | input | 1 | Synchronous active-high reset |
| tck_i | input | 1 | Observed test clock |
| tms_i | input | 1 | Observed mode select |
| tdi_i | input | 1 | Observed data toward the target |
| tdo_i | input | 1 | Observed data from the target |
| state_o | output | 4 | Tracked controller state |
| chg_valid_o | output | 1 | One-cycle strobe per rising test clock edge |
| chg_from_o | output | 4 | State left at that edge |
| chg_to_o | output | 4 | State entered at that edge |
| rec_valid_o | output | 1 | One-cycle strobe when a scan record is published |
| rec_is_ir_o | output | 1 | 1 for an instruction scan, 0 for a data scan |
| rec_tdi_o | output | W | Data-in bits, first bit in bit 0 |
| rec_tdo_o | output | W | Data-out bits, first bit in bit 0 |
| rec_count_o | output | clog2(W+1) | Number of valid bits |
| rec_overflow_o | output | 1 | Scan was longer than W |

## Verification
Directed scans cover several distinct cases. An instruction scan checks that the bits come out in the right order. A data scan that goes through Pause checks that the value on the edge leaving Exit1 toward Pause is not counted. A scan with no bits tells a count of 0 apart from leftover data. A data scan longer than W checks that the count stops at W and that overflow is flagged. A run of mode-select ones into Test-Logic-Reset checks the reset-branch edges. Long random runs of mode select, data-in and data-out reach every state and walk every transition. Each of these edges is compared against a bench model of the state and of the expected records. Each test clock cycle also checks that the low phase leaves the state and the event count unchanged.

// File: rtl/jtmon_pkg.sv
package jtmon_pkg;

    typedef enum logic [3:0] {
        ST_RESET    = 4'd0,
        ST_IDLE     = 4'd1,
        ST_DR_SEL   = 4'd2,
        ST_DR_CAP   = 4'd3,
        ST_DR_SHIFT = 4'd4,
        ST_DR_EXIT1 = 4'd5,
        ST_DR_PAUSE = 4'd6,
        ST_DR_EXIT2 = 4'd7,
        ST_DR_UPD   = 4'd8,
        ST_IR_SEL   = 4'd9,
        ST_IR_CAP   = 4'd10,
        ST_IR_SHIFT = 4'd11,
        ST_IR_EXIT1 = 4'd12,
        ST_IR_PAUSE = 4'd13,
        ST_IR_EXIT2 = 4'd14,
        ST_IR_UPD   = 4'd15
    } tap_st_e;

    function automatic tap_st_e tap_next(tap_st_e s, logic tms);
        tap_st_e n;
        case (s)
            ST_RESET:    n = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     n = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   n = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   n = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: n = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: n = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: n = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: n = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   n = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   n = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   n = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: n = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: n = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: n = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: n = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            default:     n = tms ? ST_DR_SEL   : ST_IDLE;
        endcase
        return n;
    endfunction

    function automatic logic tap_is_shift(tap_st_e s);
        return (s == ST_DR_SHIFT) || (s == ST_IR_SHIFT);
    endfunction

    function automatic logic tap_is_capture(tap_st_e s);
        return (s == ST_DR_CAP) || (s == ST_IR_CAP);
    endfunction

    function automatic logic tap_is_update(tap_st_e s);
        return (s == ST_DR_UPD) || (s == ST_IR_UPD);
    endfunction

    function automatic logic tap_is_exit(tap_st_e s);
        return (s == ST_DR_EXIT1) || (s == ST_IR_EXIT1) ||
               (s == ST_DR_EXIT2) || (s == ST_IR_EXIT2);
    endfunction

endpackage

// File: rtl/jtmon_sync.sv
module jtmon_sync #(
    parameter int N = 1,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/jtmon_tap_track.sv
module jtmon_tap_track
    import jtmon_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    step,
    input  logic    tms,
    output tap_st_e cur_o,
    output tap_st_e nxt_o,
    output logic    chg_valid_o,
    output tap_st_e chg_from_o,
    output tap_st_e chg_to_o
);
    tap_st_e state_q;

    assign cur_o = state_q;
    assign nxt_o = tap_next(state_q, tms);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            chg_valid_o <= 1'b0;
            chg_from_o  <= ST_IDLE;
            chg_to_o    <= ST_IDLE;
        end else begin
            chg_valid_o <= step;
            if (step) begin
                state_q    <= nxt_o;
                chg_from_o <= state_q;
                chg_to_o   <= nxt_o;
            end
        end
    end

    // R3
    state_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(state_q));

    // R4
    chg_from_chk: assert property (@(posedge clk) disable iff (rst)
        chg_valid_o |-> (chg_from_o == $past(state_q)));

    // R2
    chg_legal_chk: assert property (@(posedge clk) disable iff (rst)
        chg_valid_o |-> ((chg_to_o == tap_next(chg_from_o, 1'b0)) ||
                         (chg_to_o == tap_next(chg_from_o, 1'b1))));
endmodule

// File: rtl/jtmon_scan_cap.sv
module jtmon_scan_cap
    import jtmon_pkg::*;
#(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  tap_st_e       cur,
    input  tap_st_e       nxt,
    input  logic          tdi,
    input  logic          tdo,
    output logic          rec_valid_o,
    output logic          rec_is_ir_o,
    output logic [W-1:0]  rec_tdi_o,
    output logic [W-1:0]  rec_tdo_o,
    output logic [CW-1:0] rec_count_o,
    output logic          rec_overflow_o
);
    localparam logic [CW-1:0] CNT_MAX = CW'(W);

    logic [W-1:0]  acc_tdi, acc_tdo;
    logic [CW-1:0] acc_cnt;
    logic          acc_ovf;
    logic          take_bit, full;

    assign take_bit = step && tap_is_shift(cur);
    assign full     = (acc_cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_tdi        <= '0;
            acc_tdo        <= '0;
            acc_cnt        <= '0;
            acc_ovf        <= 1'b0;
            rec_valid_o    <= 1'b0;
            rec_is_ir_o    <= 1'b0;
            rec_tdi_o      <= '0;
            rec_tdo_o      <= '0;
            rec_count_o    <= '0;
            rec_overflow_o <= 1'b0;
        end else begin
            rec_valid_o <= 1'b0;
            if (step && (tap_is_update(nxt) || tap_is_capture(nxt))) begin
                acc_tdi <= '0;
                acc_tdo <= '0;
                acc_cnt <= '0;
                acc_ovf <= 1'b0;
            end else if (take_bit) begin
                if (full) begin
                    acc_ovf <= 1'b1;
                end else begin
                    acc_tdi <= acc_tdi | ({{(W-1){1'b0}}, tdi} << acc_cnt);
                    acc_tdo <= acc_tdo | ({{(W-1){1'b0}}, tdo} << acc_cnt);
                    acc_cnt <= acc_cnt + 1'b1;
                end
            end
            if (step && tap_is_update(nxt)) begin
                rec_valid_o    <= 1'b1;
                rec_is_ir_o    <= (nxt == ST_IR_UPD);
                rec_tdi_o      <= acc_tdi;
                rec_tdo_o      <= acc_tdo;
                rec_count_o    <= acc_cnt;
                rec_overflow_o <= acc_ovf;
            end
        end
    end

    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid_o |-> (rec_count_o <= CNT_MAX));

    // R9
    ovf_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (rec_valid_o && rec_overflow_o) |-> (rec_count_o == CNT_MAX));

    // R7
    rec_origin_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid_o |-> $past(tap_is_exit(cur)));

    // R7
    rec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid_o |=> !rec_valid_o);
endmodule

// File: rtl/jtmon_top.sv
module jtmon_top
    import jtmon_pkg::*;
#(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tck_i,
    input  logic          tms_i,
    input  logic          tdi_i,
    input  logic          tdo_i,
    output logic [3:0]    state_o,
    output logic          chg_valid_o,
    output logic [3:0]    chg_from_o,
    output logic [3:0]    chg_to_o,
    output logic          rec_valid_o,
    output logic          rec_is_ir_o,
    output logic [W-1:0]  rec_tdi_o,
    output logic [W-1:0]  rec_tdo_o,
    output logic [CW-1:0] rec_count_o,
    output logic          rec_overflow_o
);
    logic [3:0] pins_s;
    logic       tck_d, step;
    tap_st_e    cur, nxt, from_e, to_e;

    jtmon_sync #(.N(4), .RST_VAL(4'b1000)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({tck_i, tms_i, tdi_i, tdo_i}),
        .q   (pins_s)
    );

    always_ff @(posedge clk) begin
        if (rst) tck_d <= 1'b1;
        else     tck_d <= pins_s[3];
    end

    assign step = pins_s[3] && !tck_d;

    jtmon_tap_track u_track (
        .clk         (clk),
        .rst         (rst),
        .step        (step),
        .tms         (pins_s[2]),
        .cur_o       (cur),
        .nxt_o       (nxt),
        .chg_valid_o (chg_valid_o),
        .chg_from_o  (from_e),
        .chg_to_o    (to_e)
    );

    jtmon_scan_cap #(.W(W), .CW(CW)) u_cap (
        .clk            (clk),
        .rst            (rst),
        .step           (step),
        .cur            (cur),
        .nxt            (nxt),
        .tdi            (pins_s[1]),
        .tdo            (pins_s[0]),
        .rec_valid_o    (rec_valid_o),
        .rec_is_ir_o    (rec_is_ir_o),
        .rec_tdi_o      (rec_tdi_o),
        .rec_tdo_o      (rec_tdo_o),
        .rec_count_o    (rec_count_o),
        .rec_overflow_o (rec_overflow_o)
    );

    assign state_o    = cur;
    assign chg_from_o = from_e;
    assign chg_to_o   = to_e;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (state_o == 4'd1 && !chg_valid_o && !rec_valid_o));
endmodule

// File: tb/sim_jtmon_top.sv
module sim_jtmon_top;
    localparam int W  = 64;
    localparam int CW = $clog2(W + 1);

    logic clk = 1'b0, rst = 1'b1;
    logic tck_i = 1'b0, tms_i = 1'b0, tdi_i = 1'b0, tdo_i = 1'b0;
    logic [3:0] state_o, chg_from_o, chg_to_o;
    logic chg_valid_o, rec_valid_o, rec_is_ir_o, rec_overflow_o;
    logic [W-1:0] rec_tdi_o, rec_tdo_o;
    logic [CW-1:0] rec_count_o;

    always #2.5 clk = ~clk;

    jtmon_top #(.W(W)) u0 (
        .clk(clk), .rst(rst), .tck_i(tck_i), .tms_i(tms_i), .tdi_i(tdi_i),
        .tdo_i(tdo_i), .state_o(state_o), .chg_valid_o(chg_valid_o),
        .chg_from_o(chg_from_o), .chg_to_o(chg_to_o), .rec_valid_o(rec_valid_o),
        .rec_is_ir_o(rec_is_ir_o), .rec_tdi_o(rec_tdi_o), .rec_tdo_o(rec_tdo_o),
        .rec_count_o(rec_count_o), .rec_overflow_o(rec_overflow_o)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // monitor: pulses seen at the ports
    int chg_seen = 0, rec_seen = 0;
    logic [3:0] m_from, m_to;
    logic m_ir, m_ovf;
    logic [W-1:0] m_tdi, m_tdo;
    logic [CW-1:0] m_cnt;
    always @(negedge clk) begin
        if (!rst && chg_valid_o) begin
            chg_seen++; m_from = chg_from_o; m_to = chg_to_o;
        end
        if (!rst && rec_valid_o) begin
            rec_seen++; m_ir = rec_is_ir_o; m_tdi = rec_tdi_o; m_tdo = rec_tdo_o;
            m_cnt = rec_count_o; m_ovf = rec_overflow_o;
        end
    end

    // bench model of the controller (R2 table, R1 encoding)
    function automatic logic [3:0] bnext(logic [3:0] s, logic m);
        case (s)
            4'd0:  return m ? 4'd0 : 4'd1;
            4'd1:  return m ? 4'd2 : 4'd1;
            4'd2:  return m ? 4'd9 : 4'd3;
            4'd9:  return m ? 4'd0 : 4'd10;
            4'd8, 4'd15: return m ? 4'd2 : 4'd1;
            default: begin
                // branch-relative: 3 cap,4 shift,5 exit1,6 pause,7 exit2 (+7 for IR)
                logic [3:0] b; logic [3:0] o, r;
                b = (s >= 4'd10) ? 4'd7 : 4'd0;
                o = s - b;
                case (o)
                    4'd3, 4'd4: r = m ? 4'd5 : 4'd4;
                    4'd5:       r = m ? 4'd8 : 4'd6;
                    4'd6:       r = m ? 4'd7 : 4'd6;
                    default:    r = m ? 4'd8 : 4'd4;
                endcase
                return r + b;
            end
        endcase
    endfunction

    logic [3:0] exp_st = 4'd1;
    logic [W-1:0] e_tdi = '0, e_tdo = '0;
    int e_cnt = 0;
    bit e_ovf = 0;

    task automatic tick(input logic m, input logic di, input logic dout);
        logic [3:0] prev;
        int c0, r0;
        bit want_rec, want_ir, want_ovf;
        logic [W-1:0] w_tdi, w_tdo;
        int w_cnt;
        @(negedge clk);
        c0 = chg_seen; r0 = rec_seen;
        tck_i = 1'b0; tms_i = m; tdi_i = di; tdo_i = dout;
        repeat (6) @(negedge clk);
        #1;
        chk(chg_seen == c0, "R3 no event on falling edge", chg_seen, c0);
        chk(state_o == exp_st, "R3 state held on falling edge", state_o, exp_st);
        prev = exp_st;
        exp_st = bnext(prev, m);
        want_rec = 0; want_ir = 0; want_ovf = 0; w_tdi = '0; w_tdo = '0; w_cnt = 0;
        if (prev == 4'd4 || prev == 4'd11) begin
            if (e_cnt < W) begin
                e_tdi[e_cnt] = di; e_tdo[e_cnt] = dout; e_cnt++;
            end else e_ovf = 1;
        end
        if (exp_st == 4'd8 || exp_st == 4'd15) begin
            want_rec = 1; want_ir = (exp_st == 4'd15);
            w_tdi = e_tdi; w_tdo = e_tdo; w_cnt = e_cnt; want_ovf = e_ovf;
        end
        if (exp_st == 4'd8 || exp_st == 4'd15 || exp_st == 4'd3 || exp_st == 4'd10) begin
            e_tdi = '0; e_tdo = '0; e_cnt = 0; e_ovf = 0;
        end
        @(negedge clk);
        tck_i = 1'b1;
        repeat (6) @(negedge clk);
        #1;
        chk(state_o == exp_st, "R2 next state", state_o, exp_st);
        chk(chg_seen == c0 + 1, "R4 one event per rising edge", chg_seen, c0 + 1);
        chk(m_from == prev && m_to == exp_st, "R4 event from/to",
            {m_from, m_to}, {prev, exp_st});
        chk(rec_seen == r0 + (want_rec ? 1 : 0), "R7 record strobe count",
            rec_seen, r0 + (want_rec ? 1 : 0));
        if (want_rec) begin
            chk(m_ir == want_ir, "R7 record tag", m_ir, want_ir);
            chk(m_tdi == w_tdi, "R5 R6 tdi vector", m_tdi, w_tdi);
            chk(m_tdo == w_tdo, "R5 R6 tdo vector", m_tdo, w_tdo);
            chk(int'(m_cnt) == w_cnt, "R8 bit count", m_cnt, w_cnt);
            chk(m_ovf == want_ovf, "R9 overflow flag", m_ovf, want_ovf);
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h51C0_0D3);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R1 reset state
        chk(state_o == 4'd1, "R1 reset state idle", state_o, 1);
        chk(!chg_valid_o && !rec_valid_o, "R1 no strobe after reset",
            {chg_valid_o, rec_valid_o}, 0);

        // R5 R7 IR scan, 5 bits, junk on Exit1->Update edge (R6)
        tick(1, 0, 0); tick(1, 0, 0); tick(0, 0, 0); tick(0, 0, 0);
        tick(0, 1, 0); tick(0, 0, 1); tick(0, 1, 1); tick(0, 1, 1); tick(1, 0, 1);
        tick(1, 1, 1);
        chk(m_ir == 1 && m_cnt == 5, "R7 R8 IR scan tag and length", {m_ir, m_cnt}, {1'b1, 7'd5});
        chk(m_tdi == 64'h0D && m_tdo == 64'h1E, "R5 IR scan LSB-first", m_tdi, 64'h0D);
        tick(0, 0, 0);

        // R6 DR scan through Pause: bits 1,1,0 then 0,1
        tick(1, 0, 0); tick(0, 0, 0); tick(0, 0, 0);
        tick(0, 1, 0); tick(0, 1, 0); tick(1, 0, 0);
        tick(0, 1, 1); tick(0, 1, 1); tick(1, 0, 0); tick(0, 0, 0);
        tick(0, 0, 0); tick(1, 1, 0); tick(1, 1, 1);
        chk(m_ir == 0 && m_cnt == 5, "R6 DR pause scan length", {m_ir, m_cnt}, {1'b0, 7'd5});
        chk(m_tdi == 64'h13 && m_tdo == 64'h0, "R6 DR pause scan data", m_tdi, 64'h13);

        // R8 zero-length scan: Capture->Exit1->Update
        tick(1, 0, 0); tick(0, 0, 0); tick(1, 0, 0); tick(1, 1, 1);
        chk(m_cnt == 0 && m_tdi == 0 && !m_ovf, "R8 R10 empty scan", m_cnt, 0);

        // R9 overflow: 70 bits into a 64-bit capture
        tick(1, 0, 0); tick(0, 0, 0); tick(0, 0, 0);
        for (int i = 0; i < 70; i++) tick(i == 69, (i % 3) == 0, i[0]);
        tick(1, 0, 0);
        chk(m_ovf == 1 && m_cnt == 64, "R9 saturate and flag", {m_ovf, m_cnt}, {1'b1, 7'd64});

        // R2 reset branch: ones lead to Test-Logic-Reset
        tick(1, 0, 0); tick(1, 0, 0); tick(1, 0, 0); tick(1, 0, 0);
        chk(state_o == 4'd0, "R2 reach reset state", state_o, 0);
        tick(0, 0, 0);

        // random stimulus against the bench model (all requirements)
        for (int i = 0; i < 1500; i++) tick($urandom % 2, $urandom % 2, $urandom % 2);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog act=1 exp=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule